// File: doc/BRIEF.md
# Power-Management Event Status and Enable Registers

This block holds the pair of 16-bit registers that record power-management events and select which of them may interrupt the processor. Four event sources feed it with one-cycle set pulses: the carry out of the free-running power-management timer, a global event, the power button and the sleep button. Software sees both registers through a small I/O window of four bytes. It can read them with byte, word or dword accesses at any byte offset. Status bits are cleared by writing ones to them. Enable bits are written directly.

The block drives one level-sensitive system control interrupt. The line stays high while at least one event bit is pending in status and also enabled. It falls as soon as software clears the pending bit or the enable bit. The I/O window sits at one of two fixed base addresses. A version input picks which base is in use.

Top module: `pm1_evt_regs`

## Requirements
- R1: After reset, status and enable read as zero, the interrupt is low and the window uses the version-0 base address.
- R2: The interrupt output is high exactly when status AND enable AND the event mask (bits 0, 5, 8, 9) is nonzero. The level reflects the register contents in the cycle after a write or event pulse.
- R3: A pulse on the timer-carry, global, power-button or sleep-button input sets status bit 0, 5, 8 or 9 respectively, at the next clock edge. No other status bit can ever become one.
- R4: A byte written at offset 0 or 1 clears the status bits of the low or high byte where the data byte holds ones. The other status bits keep their value.
- R5: A byte written at offset 2 or 3 replaces only the low or high byte of the enable register.
- R6: A write of N bytes at offset k is handled as byte lanes. Data byte i (counted from the least significant end) goes to offset k+i. Lanes landing above offset 3 are dropped.
- R7: The size code io_size encodes 1 byte (0), 2 bytes (1) and 4 bytes (2 or 3). A read at offset k returns the 32-bit word {enable, status} shifted right by 8*k bits. The result is cut to 8 or 16 bits for byte and word reads. io_rdata is zero when no read hits the window.
- R8: io_hit is high when io_addr lies in the four bytes starting at the selected base: 16'h1F40 for version 0, 16'h0C00 for version 1. Accesses with io_hit low change nothing. A version request equal to the current version leaves the window where it is.
- R9: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O byte address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_size | input | 2 | Access size code (0: byte, 1: word, 2/3: dword) |
| io_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| io_rdata | output | 32 | Read data, combinational |
| io_hit | output | 1 | Address falls inside the selected window |
| evt_tmr_carry | input | 1 | Timer carry event pulse |
| evt_global | input | 1 | Global event pulse |
| evt_pwr_btn | input | 1 | Power button event pulse |
| evt_slp_btn | input | 1 | Sleep button event pulse |
| ver_req_valid | input | 1 | Window version request strobe |
| ver_req | input | 1 | Requested window version |
| win_ver | output | 1 | Current window version |
| sci | output | 1 | Level system control interrupt |

## Verification
Two situations are hard to reach from the ports. The first is an event pulse landing on the same bit as a write-one-to-clear in the same clock. The second is a multi-byte access that starts at an upper offset and spills past the end of the window. Directed steps create both on purpose: a timer pulse together with a byte clear of bit 0, and dword and word writes starting at offsets 1 and 3. Each is followed by a read that exposes the result. A long random phase then mixes all four events at a low rate with random sizes, offsets just past the window, accesses at the other base and version switches. A behavioural model checks the interrupt, the hit flag, the version and the read data on every clock.

// File: rtl/pm1_evt_pkg.sv
package pm1_evt_pkg;

   // Status / enable bit positions shared by both registers
   localparam int unsigned STS_TMR_BIT = 0;
   localparam int unsigned STS_GBL_BIT = 5;
   localparam int unsigned STS_PWR_BIT = 8;
   localparam int unsigned STS_SLP_BIT = 9;

   // Bits that may raise the interrupt
   localparam logic [15:0] EVT_MASK = 16'h0321;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_WIDE  = 2'd3
   } io_size_e;

   // Byte count of an access; the widest code is folded onto dword
   function automatic logic [3:0] size_to_bytes(input logic [1:0] sz);
      logic [3:0] n;
      case (io_size_e'(sz))
         SZ_BYTE: n = 4'd1;
         SZ_WORD: n = 4'd2;
         default: n = 4'd4;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/pm1_win_dec.sv
module pm1_win_dec #(
   parameter int unsigned          ADDR_W    = 16,
   parameter logic [ADDR_W-1:0]    BASE_V0   = 'h1F40,
   parameter logic [ADDR_W-1:0]    BASE_V1   = 'h0C00,
   parameter int unsigned          WIN_BYTES = 4,
   localparam int unsigned         OFF_W     = $clog2(WIN_BYTES)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ver,
   output logic              hit,
   output logic [OFF_W-1:0]  off
);

   generate
      if (BASE_V0 == BASE_V1) begin : g_bad_base
         $error("pm1_win_dec: both window bases are equal");
      end
      if ((1 << OFF_W) != WIN_BYTES) begin : g_bad_win
         $error("pm1_win_dec: window size must be a power of two");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] rel;

   always_comb begin
      base = ver ? BASE_V1 : BASE_V0;
      rel  = addr - base;
      hit  = (rel < ADDR_W'(WIN_BYTES));
      off  = rel[OFF_W-1:0];
   end

endmodule

// File: rtl/pm1_wr_lanes.sv
module pm1_wr_lanes
   import pm1_evt_pkg::*;
#(
   parameter int unsigned  NBYTES = 4,
   localparam int unsigned OFF_W  = $clog2(NBYTES),
   localparam int unsigned DATA_W = 8 * NBYTES
) (
   input  logic              wr,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] wdata,
   output logic [NBYTES-1:0] byte_we,
   output logic [DATA_W-1:0] byte_data
);

   localparam int unsigned NB_W = 4;

   logic [NB_W-1:0] nbytes;
   assign nbytes = size_to_bytes(size);

   // Register byte j receives data lane (j - off) when that lane exists
   for (genvar j = 0; j < NBYTES; j++) begin : g_lane
      logic [OFF_W:0]    rel;
      logic [DATA_W-1:0] shifted;
      logic              above;

      always_comb begin
         above   = ((OFF_W+1)'(j) >= {1'b0, off});
         rel     = (OFF_W+1)'(j) - {1'b0, off};
         shifted = wdata >> {rel, 3'b000};
      end

      assign byte_we[j]          = wr && above && (NB_W'(rel) < nbytes);
      assign byte_data[j*8 +: 8] = shifted[7:0];
   end

endmodule

// File: rtl/pm1_rd_path.sv
module pm1_rd_path
   import pm1_evt_pkg::*;
#(
   parameter int unsigned  NBYTES = 4,
   localparam int unsigned OFF_W  = $clog2(NBYTES),
   localparam int unsigned DATA_W = 8 * NBYTES
) (
   input  logic              rd,
   input  logic              hit,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned NB_W = 4;

   logic [NB_W-1:0]   nbytes;
   logic [DATA_W-1:0] shifted;

   assign nbytes  = size_to_bytes(size);
   assign shifted = word >> {off, 3'b000};

   // Keep only the lanes that belong to the access size
   for (genvar j = 0; j < NBYTES; j++) begin : g_keep
      logic keep;
      assign keep = rd && hit && (NB_W'(j) < nbytes);
      assign rdata[j*8 +: 8] = keep ? shifted[j*8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/pm1_evt_core.sv
module pm1_evt_core #(
   parameter int unsigned    REG_BYTES      = 2,
   localparam int unsigned   REG_W          = 8 * REG_BYTES,
   localparam int unsigned   WIN_BYTES      = 2 * REG_BYTES,
   parameter logic [REG_W-1:0] SCI_MASK     = REG_W'(pm1_evt_pkg::EVT_MASK),
   parameter logic [REG_W-1:0] STS_IMPL     = REG_W'(pm1_evt_pkg::EVT_MASK),
   parameter bit             SCI_REGISTERED = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WIN_BYTES-1:0]   byte_we,
   input  logic [8*WIN_BYTES-1:0] byte_data,
   input  logic [REG_W-1:0]       set_vec,
   output logic [REG_W-1:0]       sts_q,
   output logic [REG_W-1:0]       en_q,
   output logic                   sci
);

   logic [REG_W-1:0] clr_vec;
   logic [REG_W-1:0] sts_d;
   logic [REG_W-1:0] en_d;

   // Status bytes occupy the low lanes, enable bytes the high lanes
   for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
      assign clr_vec[b*8 +: 8] = byte_we[b] ? byte_data[b*8 +: 8] : 8'h00;
      assign en_d[b*8 +: 8]    = byte_we[REG_BYTES+b]
                                 ? byte_data[(REG_BYTES+b)*8 +: 8]
                                 : en_q[b*8 +: 8];
   end

   // A set in the same cycle overrides the clear
   assign sts_d = ((sts_q & ~clr_vec) | set_vec) & STS_IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= sts_d;
         en_q  <= en_d;
      end
   end

   generate
      if (SCI_REGISTERED) begin : g_sci_ff
         logic sci_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sci_q <= 1'b0;
            else        sci_q <= |(sts_d & en_d & SCI_MASK);
         end
         assign sci = sci_q;
      end else begin : g_sci_comb
         assign sci = |(sts_q & en_q & SCI_MASK);
      end
   endgenerate

endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
   import pm1_evt_pkg::*;
#(
   parameter int unsigned       ADDR_W         = 16,
   parameter logic [ADDR_W-1:0] BASE_V0        = 'h1F40,
   parameter logic [ADDR_W-1:0] BASE_V1        = 'h0C00,
   parameter int unsigned       REG_BYTES      = 2,
   parameter bit                SCI_REGISTERED = 1'b0,
   localparam int unsigned      WIN_BYTES      = 2 * REG_BYTES,
   localparam int unsigned      DATA_W         = 8 * WIN_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [1:0]        io_size,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_hit,
   input  logic              evt_tmr_carry,
   input  logic              evt_global,
   input  logic              evt_pwr_btn,
   input  logic              evt_slp_btn,
   input  logic              ver_req_valid,
   input  logic              ver_req,
   output logic              win_ver,
   output logic              sci
);

   localparam int unsigned REG_W = 8 * REG_BYTES;
   localparam int unsigned OFF_W = $clog2(WIN_BYTES);

   generate
      if (REG_BYTES < 2 || REG_BYTES > 4) begin : g_bad_regs
         $error("pm1_evt_regs: REG_BYTES must lie in 2..4");
      end
      if ((1 << $clog2(REG_BYTES)) != REG_BYTES) begin : g_bad_pow
         $error("pm1_evt_regs: REG_BYTES must be a power of two");
      end
   endgenerate

   logic                 win_ver_q;
   logic [OFF_W-1:0]     win_off;
   logic                 win_hit;
   logic [WIN_BYTES-1:0] byte_we;
   logic [DATA_W-1:0]    byte_data;
   logic [REG_W-1:0]     set_vec;
   logic [REG_W-1:0]     sts_q;
   logic [REG_W-1:0]     en_q;

   // Window version: only a differing request moves the window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  win_ver_q <= 1'b0;
      else if (ver_req_valid && ver_req != win_ver_q) win_ver_q <= ver_req;
   end

   always_comb begin
      set_vec              = '0;
      set_vec[STS_TMR_BIT] = evt_tmr_carry;
      set_vec[STS_GBL_BIT] = evt_global;
      set_vec[STS_PWR_BIT] = evt_pwr_btn;
      set_vec[STS_SLP_BIT] = evt_slp_btn;
   end

   pm1_win_dec #(
      .ADDR_W    (ADDR_W),
      .BASE_V0   (BASE_V0),
      .BASE_V1   (BASE_V1),
      .WIN_BYTES (WIN_BYTES)
   ) u_win (
      .addr (io_addr),
      .ver  (win_ver_q),
      .hit  (win_hit),
      .off  (win_off)
   );

   pm1_wr_lanes #(
      .NBYTES (WIN_BYTES)
   ) u_wr (
      .wr        (io_wr && win_hit),
      .off       (win_off),
      .size      (io_size),
      .wdata     (io_wdata),
      .byte_we   (byte_we),
      .byte_data (byte_data)
   );

   pm1_evt_core #(
      .REG_BYTES      (REG_BYTES),
      .SCI_REGISTERED (SCI_REGISTERED)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_we   (byte_we),
      .byte_data (byte_data),
      .set_vec   (set_vec),
      .sts_q     (sts_q),
      .en_q      (en_q),
      .sci       (sci)
   );

   pm1_rd_path #(
      .NBYTES (WIN_BYTES)
   ) u_rd (
      .rd    (io_rd),
      .hit   (win_hit),
      .off   (win_off),
      .size  (io_size),
      .word  ({en_q, sts_q}),
      .rdata (io_rdata)
   );

   assign io_hit  = win_hit;
   assign win_ver = win_ver_q;

endmodule

// File: rtl/pm1_evt_chk.sv
module pm1_evt_chk #(
   parameter int unsigned REG_W  = 16,
   parameter int unsigned OFF_W  = 2,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr,
   input logic              io_hit,
   input logic [OFF_W-1:0]  off,
   input logic [DATA_W-1:0] io_wdata,
   input logic [REG_W-1:0]  evt,
   input logic [REG_W-1:0]  sts,
   input logic [REG_W-1:0]  en,
   input logic              sci,
   input logic              ver_req_valid,
   input logic              ver_req,
   input logic              win_ver
);
   import pm1_evt_pkg::*;

   localparam logic [REG_W-1:0] MASK = REG_W'(EVT_MASK);

   logic clr_tmr_wr;
   assign clr_tmr_wr = io_wr && io_hit && (off == '0) && io_wdata[0];

   p_sci_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((en & MASK) == '0) |-> !sci);

   p_sci_timer_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en[STS_TMR_BIT] && sts[STS_TMR_BIT]) |-> sci);

   p_pwr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt[STS_PWR_BIT] |=> sts[STS_PWR_BIT]);

   p_no_stray_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts & ~MASK) == '0));

   p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_tmr_wr && !evt[STS_TMR_BIT]) |=> !sts[STS_TMR_BIT]);

   p_sts_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_wr && evt == '0) |=> $stable(sts));

   p_en_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_hit) |=> $stable(en));

   p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_tmr_wr && evt[STS_TMR_BIT]) |=> sts[STS_TMR_BIT]);

   p_same_ver_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ver_req_valid && ver_req == win_ver) |=> $stable(win_ver));

endmodule

bind pm1_evt_regs pm1_evt_chk #(
   .REG_W  (REG_W),
   .OFF_W  (OFF_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .io_wr         (io_wr),
   .io_hit        (io_hit),
   .off           (win_off),
   .io_wdata      (io_wdata),
   .evt           (set_vec),
   .sts           (sts_q),
   .en            (en_q),
   .sci           (sci),
   .ver_req_valid (ver_req_valid),
   .ver_req       (ver_req),
   .win_ver       (win_ver)
);

// File: tb/pm1_evt_regs_tb.sv
`timescale 1ns/1ps
module pm1_evt_regs_tb;

   localparam logic [15:0] B0 = 16'h1F40;
   localparam logic [15:0] B1 = 16'h0C00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 1'b0, io_wr = 1'b0;
   logic [1:0]  io_size = '0;
   logic [31:0] io_wdata = '0;
   logic [31:0] io_rdata;
   logic        io_hit;
   logic        evt_tmr_carry = 1'b0, evt_global = 1'b0;
   logic        evt_pwr_btn = 1'b0, evt_slp_btn = 1'b0;
   logic        ver_req_valid = 1'b0, ver_req = 1'b0;
   logic        win_ver, sci;

   int n_chk = 0;
   int n_fail = 0;
   int m_sts = 0, m_en = 0, m_ver = 0;
   logic [31:0] r;

   always #4 clk = ~clk;

   pm1_evt_regs u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
      .evt_tmr_carry(evt_tmr_carry), .evt_global(evt_global),
      .evt_pwr_btn(evt_pwr_btn), .evt_slp_btn(evt_slp_btn),
      .ver_req_valid(ver_req_valid), .ver_req(ver_req),
      .win_ver(win_ver), .sci(sci)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // One clock of stimulus; outputs compared with the model before the edge
   task automatic step(input logic rd, input logic wr, input logic [15:0] addr,
                       input logic [1:0] size, input logic [31:0] data, input logic [3:0] ev,
                       input logic vv, input logic vr, output logic [31:0] rdat);
      logic [15:0] d;
      int          off, n;
      bit          hit;
      logic [31:0] word, exp_rd, msk;
      int          clr;
      io_rd = rd; io_wr = wr; io_addr = addr; io_size = size; io_wdata = data;
      {evt_slp_btn, evt_pwr_btn, evt_global, evt_tmr_carry} = ev;
      ver_req_valid = vv; ver_req = vr;
      #1;
      d   = addr - ((m_ver != 0) ? B1 : B0);
      hit = (d < 16'd4);
      off = int'(d[1:0]);
      n   = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
      word = {m_en[15:0], m_sts[15:0]};
      msk  = (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
      exp_rd = (rd && hit) ? ((word >> (8 * off)) & msk) : 32'h0;
      chk(io_hit === hit, "R8 hit", {31'b0, io_hit}, {31'b0, hit});
      chk(win_ver === m_ver[0], "R8 version", {31'b0, win_ver}, m_ver);
      chk(sci === ((m_en & m_sts & 'h321) != 0), "R2 level", {31'b0, sci},
          {31'b0, ((m_en & m_sts & 'h321) != 0)});
      chk(io_rdata === exp_rd, "R7 read data", io_rdata, exp_rd);
      rdat = io_rdata;
      @(posedge clk);
      clr = 0;
      if (wr && hit) begin
         for (int i = 0; i < n; i++) begin
            int o, b;
            o = off + i;
            b = (data >> (8 * i)) & 'hFF;
            if (o == 0) clr = clr | b;
            else if (o == 1) clr = clr | (b << 8);
            else if (o == 2) m_en = (m_en & 'hFF00) | b;
            else if (o == 3) m_en = (m_en & 'h00FF) | (b << 8);
         end
      end
      m_sts = (m_sts & ~clr) | (ev[0] ? 'h001 : 0) | (ev[1] ? 'h020 : 0)
              | (ev[2] ? 'h100 : 0) | (ev[3] ? 'h200 : 0);
      if (vv) m_ver = vr ? 1 : 0;
      @(negedge clk);
      io_rd = 0; io_wr = 0; ver_req_valid = 0;
      {evt_slp_btn, evt_pwr_btn, evt_global, evt_tmr_carry} = 4'b0;
   endtask

   task automatic rchk(input logic [15:0] addr, input logic [1:0] size,
                       input logic [31:0] exp, input string tag);
      logic [31:0] v;
      step(1'b1, 1'b0, addr, size, 32'h0, 4'b0, 1'b0, 1'b0, v);
      chk(v === exp, tag, v, exp);
   endtask

   task automatic wr(input logic [15:0] addr, input logic [1:0] size,
                     input logic [31:0] data, input logic [3:0] ev);
      logic [31:0] v;
      step(1'b0, 1'b1, addr, size, data, ev, 1'b0, 1'b0, v);
   endtask

   initial begin : watchdog
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(sci === 1'b0, "R1 interrupt in reset", {31'b0, sci}, 32'h0);
      chk(win_ver === 1'b0, "R1 version in reset", {31'b0, win_ver}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rchk(B0, 2'd2, 32'h0, "R1 registers after reset");

      // R3: each event sets its own bit
      step(0, 0, 16'h0, 0, 0, 4'b1100, 0, 0, r);
      rchk(B0, 2'd1, 32'h0300, "R3 button bits");
      step(0, 0, 16'h0, 0, 0, 4'b0011, 0, 0, r);
      rchk(B0, 2'd2, 32'h0000_0321, "R3 all event bits");
      chk(sci === 1'b0, "R2 disabled keeps low", {31'b0, sci}, 32'h0);

      // R4: write one to clear, zeros preserve
      wr(B0, 2'd1, 32'hFFFF, 4'b0);
      rchk(B0, 2'd1, 32'h0, "R4 clear all");
      step(0, 0, 16'h0, 0, 0, 4'b0001, 0, 0, r);
      wr(B0, 2'd0, 32'h20, 4'b0);
      rchk(B0, 2'd1, 32'h0001, "R4 zero bits kept");

      // R5 / R2: enable bytes
      wr(B0 + 2, 2'd0, 32'h01, 4'b0);
      chk(sci === 1'b1, "R2 enabled pending raises", {31'b0, sci}, 32'h1);
      rchk(B0, 2'd2, 32'h0001_0001, "R5 enable low byte");
      wr(B0 + 3, 2'd0, 32'hAB, 4'b0);
      rchk(B0 + 2, 2'd1, 32'hAB01, "R5 enable high byte");
      wr(B0, 2'd0, 32'h01, 4'b0);
      chk(sci === 1'b0, "R4 clear drops interrupt", {31'b0, sci}, 32'h0);

      // R9: set and clear in one cycle
      wr(B0, 2'd0, 32'h01, 4'b0001);
      rchk(B0, 2'd0, 32'h01, "R9 set wins");
      chk(sci === 1'b1, "R9 interrupt after collision", {31'b0, sci}, 32'h1);

      // R6: lanes spilling past offset 3
      wr(B0 + 1, 2'd2, 32'h4433_2211, 4'b0);
      rchk(B0, 2'd2, 32'h3322_0001, "R6 dword at offset 1");
      wr(B0 + 3, 2'd1, 32'hBEEF, 4'b0);
      rchk(B0 + 2, 2'd1, 32'hEF22, "R6 word at offset 3");

      // R7: shifted and truncated reads
      rchk(B0 + 1, 2'd0, 32'h00, "R7 byte offset 1");
      rchk(B0 + 2, 2'd0, 32'h22, "R7 byte offset 2");
      rchk(B0 + 1, 2'd1, 32'h2200, "R7 word offset 1");
      rchk(B0 + 3, 2'd2, 32'hEF, "R7 dword offset 3");
      rchk(B0 + 3, 2'd3, 32'hEF, "R7 size code 3");

      // R8: window relocation
      step(0, 0, 16'h0, 0, 0, 4'b0, 1, 1, r);
      chk(win_ver === 1'b1, "R8 move to version 1", {31'b0, win_ver}, 32'h1);
      rchk(B0, 2'd2, 32'h0, "R8 old base silent");
      wr(B0 + 2, 2'd1, 32'h0000, 4'b0);
      rchk(B1, 2'd2, 32'hEF22_0001, "R8 miss write ignored");
      step(0, 0, 16'h0, 0, 0, 4'b0, 1, 1, r);
      chk(win_ver === 1'b1, "R8 same version no-op", {31'b0, win_ver}, 32'h1);
      step(0, 0, 16'h0, 0, 0, 4'b0, 1, 0, r);
      chk(win_ver === 1'b0, "R8 back to version 0", {31'b0, win_ver}, 32'h0);

      // Random phase, checked by the model each clock (R2 R7 R8)
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] base, a;
         logic [3:0]  ev;
         base = ($urandom % 4 == 3) ? ((m_ver != 0) ? B0 : B1)
                                    : ((m_ver != 0) ? B1 : B0);
         a  = base + 16'($urandom % 6);
         ev = 4'($urandom & $urandom & $urandom);
         step(1'($urandom), 1'($urandom), a, 2'($urandom), $urandom, ev,
              ($urandom % 32 == 0), 1'($urandom), r);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule